// File: doc/BRIEF.md
# Isochronous Audio Packet Assembler

This block builds one isochronous audio packet on the device side. A single start pulse opens the packet and captures the per-packet sync values. The block then emits a quadlet stream with valid, ready and last. The stream begins with two header quadlets, and the payload follows them with no extra common header in between. The payload is interleaved sample-major: every channel of sample slot 0 comes first, then every channel of slot 1, and so on. The block pulls one 24-bit sample from an upstream stream for each payload quadlet.

Every payload quadlet carries its audio sample in the upper three bytes. The spare low byte carries clock and counter sync data, chosen by the channel's position within a group of eight. The counter and buffer-fill bytes are fixed for the whole packet. The frame number and clock phase are captured again at the start of each sample slot, so they can change part way through a packet. With the default 28 channels and 7 slots, the payload is 784 bytes and the packet is 792 bytes in total.

Top module: `iso_pkt_asm`

## Requirements
- R1: While and right after reset, `q_valid`, `q_last` and `smp_ready` are low and no packet is in progress.
- R2: `pkt_start` high while idle begins a packet, and the first header quadlet is offered on the next cycle. `pkt_start` is ignored while a packet is in progress. After the last payload quadlet is accepted, `q_valid` drops on the next cycle.
- R3: Header quadlet 0 is `{length[15:0], 16'h0000}`, where length is the payload byte count (NUM_CH*NUM_SLOTS*4, 784 by default). Header quadlet 1 is all zero.
- R4: Exactly NUM_CH*NUM_SLOTS payload quadlets follow the header directly. Quadlet p (counting from 0 after the header) belongs to slot p/NUM_CH and channel p%NUM_CH.
- R5: Bits 31..8 of each payload quadlet equal the `smp_data` value accepted on that beat.
- R6: Bits 7..0 of a payload quadlet for channel c depend on c%8: 0 = fill low byte, 1 = receive count low byte, 2 = `aux_a`, 3 = `aux_b`, 4 = receive count high byte, 5 = fill high byte, 6 = frame number, 7 = clock phase.
- R7: `rx_count`, `txbuf_fill`, `aux_a` and `aux_b` are captured in the cycle `pkt_start` is taken. Later changes to them have no effect on that packet.
- R8: `frame_num` and `clk_phase` are captured on the beat that transfers channel 0 of each slot. Channels 6 and 7 of that slot (and their repeats) carry the captured values.
- R9: `q_last` is high only together with the final payload quadlet of the packet.
- R10: A header quadlet is held stable with `q_valid` high while `q_ready` is low. During the payload, `smp_ready` equals `q_ready` and `q_valid` equals `smp_valid`, so no sample is lost or repeated under stalls on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Request to build one packet, taken only when idle |
| rx_count | input | 16 | Receive sample counter, captured per packet |
| txbuf_fill | input | 16 | Transmit buffer size, captured per packet |
| aux_a | input | 8 | Spare sync byte for lane 2, captured per packet |
| aux_b | input | 8 | Spare sync byte for lane 3, captured per packet |
| frame_num | input | 8 | Current frame number, captured per slot |
| clk_phase | input | 8 | Clock phase, captured per slot |
| smp_valid | input | 1 | Upstream sample valid |
| smp_ready | output | 1 | Upstream sample accepted when high with smp_valid |
| smp_data | input | 24 | Audio sample for the current channel and slot |
| q_valid | output | 1 | Output quadlet valid |
| q_ready | input | 1 | Downstream ready |
| q_data | output | 32 | Output quadlet |
| q_last | output | 1 | Marks the final payload quadlet |

## Verification
The bench first runs a packet with both sides always ready, which checks the header layout, the interleave order and the low-byte lane map. It then runs packets with downstream stalls, with upstream gaps, and with both at once. These show that header quadlets are held and that no payload beat is dropped or doubled. Later runs change the frame and phase every cycle, which tells slot-level capture apart from live sampling. They also change the per-packet counters right after start, which tells packet-level capture apart from live use. A start pulse in the middle of a packet checks that no second packet follows. Back-to-back packets with different sync values check that the per-packet values are captured fresh each time.

// File: rtl/iso_asm_pkg.sv
package iso_asm_pkg;

    localparam int LANE_GROUP = 8;
    localparam int QUAD_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR0 = 2'd1,
        ST_HDR1 = 2'd2,
        ST_DATA = 2'd3
    } asm_state_e;

    // Position of a channel inside its group of eight selects its sync byte.
    typedef enum logic [2:0] {
        LB_FILL_LO  = 3'd0,
        LB_RXCNT_LO = 3'd1,
        LB_AUX_A    = 3'd2,
        LB_AUX_B    = 3'd3,
        LB_RXCNT_HI = 3'd4,
        LB_FILL_HI  = 3'd5,
        LB_FRAME    = 3'd6,
        LB_PHASE    = 3'd7
    } lane_src_e;

    typedef struct packed {
        logic [15:0] rx_cnt;
        logic [15:0] fill;
        logic [7:0]  aux_a;
        logic [7:0]  aux_b;
    } pkt_sync_t;

    typedef struct packed {
        logic [7:0] frame;
        logic [7:0] phase;
    } slot_sync_t;

    function automatic lane_src_e lane_source(input logic [2:0] lane);
        return lane_src_e'(lane);
    endfunction

    function automatic logic [7:0] pick_low(input lane_src_e src,
                                            input pkt_sync_t p,
                                            input slot_sync_t s);
        logic [7:0] b;
        case (src)
            LB_FILL_LO:  b = p.fill[7:0];
            LB_RXCNT_LO: b = p.rx_cnt[7:0];
            LB_AUX_A:    b = p.aux_a;
            LB_AUX_B:    b = p.aux_b;
            LB_RXCNT_HI: b = p.rx_cnt[15:8];
            LB_FILL_HI:  b = p.fill[15:8];
            LB_FRAME:    b = s.frame;
            default:     b = s.phase;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/iso_asm_seq.sv
module iso_asm_seq
    import iso_asm_pkg::*;
#(
    parameter int NUM_CH    = 28,
    parameter int NUM_SLOTS = 7,
    parameter int CH_W      = 5,
    parameter int SLOT_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              smp_valid,
    input  logic              q_ready,
    output asm_state_e        state,
    output logic [CH_W-1:0]   ch,
    output logic [SLOT_W-1:0] slot,
    output logic              q_valid,
    output logic              smp_ready,
    output logic              start_take,
    output logic              beat_xfer,
    output logic              final_beat
);
    localparam logic [CH_W-1:0]   LAST_CH   = CH_W'(NUM_CH - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    always_comb begin
        q_valid    = (state == ST_HDR0) || (state == ST_HDR1) ||
                     ((state == ST_DATA) && smp_valid);
        smp_ready  = (state == ST_DATA) && q_ready;
        start_take = (state == ST_IDLE) && start;
        beat_xfer  = q_valid && q_ready;
        final_beat = (state == ST_DATA) && (ch == LAST_CH) && (slot == LAST_SLOT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ch    <= '0;
            slot  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_HDR0;
                        ch    <= '0;
                        slot  <= '0;
                    end
                end
                ST_HDR0: if (beat_xfer) state <= ST_HDR1;
                ST_HDR1: if (beat_xfer) state <= ST_DATA;
                default: begin
                    if (beat_xfer) begin
                        if (ch == LAST_CH) begin
                            ch <= '0;
                            if (slot == LAST_SLOT) begin
                                slot  <= '0;
                                state <= ST_IDLE;
                            end else begin
                                slot <= slot + 1'b1;
                            end
                        end else begin
                            ch <= ch + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/iso_asm_sync_hold.sv
module iso_asm_sync_hold
    import iso_asm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_pkt,
    input  pkt_sync_t  pkt_in,
    input  logic       load_slot,
    input  slot_sync_t slot_in,
    output pkt_sync_t  pkt_q,
    output slot_sync_t slot_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_q  <= '0;
            slot_q <= '0;
        end else begin
            if (load_pkt)  pkt_q  <= pkt_in;
            if (load_slot) slot_q <= slot_in;
        end
    end
endmodule

// File: rtl/iso_asm_quad_fmt.sv
module iso_asm_quad_fmt
    import iso_asm_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int LEN_BYTES = 784
) (
    input  asm_state_e          state,
    input  logic [2:0]          lane,
    input  logic [SAMPLE_W-1:0] sample,
    input  pkt_sync_t           pkt_q,
    input  slot_sync_t          slot_q,
    output logic [31:0]         quad
);
    localparam int LOW_W = 32 - SAMPLE_W;
    localparam logic [15:0] LEN_FIELD = 16'(LEN_BYTES);

    logic [7:0] low_byte;

    always_comb begin
        low_byte = pick_low(lane_source(lane), pkt_q, slot_q);
        case (state)
            ST_HDR0: quad = {LEN_FIELD, 16'h0000};
            ST_HDR1: quad = 32'h0;
            ST_DATA: quad = {sample, low_byte[LOW_W-1:0]};
            default: quad = 32'h0;
        endcase
    end
endmodule

// File: rtl/iso_pkt_asm.sv
module iso_pkt_asm
    import iso_asm_pkg::*;
#(
    parameter int NUM_CH    = 28,
    parameter int NUM_SLOTS = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pkt_start,
    input  logic [15:0] rx_count,
    input  logic [15:0] txbuf_fill,
    input  logic [7:0]  aux_a,
    input  logic [7:0]  aux_b,
    input  logic [7:0]  frame_num,
    input  logic [7:0]  clk_phase,
    input  logic        smp_valid,
    output logic        smp_ready,
    input  logic [23:0] smp_data,
    output logic        q_valid,
    input  logic        q_ready,
    output logic [31:0] q_data,
    output logic        q_last
);
    localparam int SAMPLE_W  = 24;
    localparam int CH_W      = (NUM_CH > 8) ? $clog2(NUM_CH) : 3;
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int LEN_BYTES = NUM_CH * NUM_SLOTS * QUAD_BYTES;

    asm_state_e        state;
    logic [CH_W-1:0]   ch;
    logic [SLOT_W-1:0] slot;
    logic              start_take;
    logic              beat_xfer;
    logic              final_beat;
    logic              hdr_phase;
    logic              payload_phase;
    pkt_sync_t         pkt_in, pkt_q;
    slot_sync_t        slot_in, slot_q;

    iso_asm_seq #(
        .NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .SLOT_W(SLOT_W)
    ) i_seq (
        .clk(clk), .rst(rst), .start(pkt_start), .smp_valid(smp_valid),
        .q_ready(q_ready), .state(state), .ch(ch), .slot(slot),
        .q_valid(q_valid), .smp_ready(smp_ready), .start_take(start_take),
        .beat_xfer(beat_xfer), .final_beat(final_beat)
    );

    always_comb begin
        pkt_in.rx_cnt = rx_count;
        pkt_in.fill   = txbuf_fill;
        pkt_in.aux_a  = aux_a;
        pkt_in.aux_b  = aux_b;
        slot_in.frame = frame_num;
        slot_in.phase = clk_phase;
        hdr_phase     = (state == ST_HDR0) || (state == ST_HDR1);
        payload_phase = (state == ST_DATA);
    end

    iso_asm_sync_hold i_hold (
        .clk(clk), .rst(rst),
        .load_pkt(start_take), .pkt_in(pkt_in),
        .load_slot(beat_xfer && payload_phase && (ch == '0)), .slot_in(slot_in),
        .pkt_q(pkt_q), .slot_q(slot_q)
    );

    iso_asm_quad_fmt #(
        .SAMPLE_W(SAMPLE_W), .LEN_BYTES(LEN_BYTES)
    ) i_fmt (
        .state(state), .lane(ch[2:0]), .sample(smp_data),
        .pkt_q(pkt_q), .slot_q(slot_q), .quad(q_data)
    );

    assign q_last = final_beat && smp_valid;
endmodule

// File: rtl/iso_pkt_asm_chk.sv
module iso_pkt_asm_chk #(
    parameter int NUM_CH    = 28,
    parameter int NUM_SLOTS = 7
) (
    input logic        clk,
    input logic        rst,
    input logic        q_valid,
    input logic        q_ready,
    input logic        q_last,
    input logic [31:0] q_data,
    input logic        smp_ready,
    input logic        hdr_phase,
    input logic        payload_phase
);
    localparam int TOTAL = NUM_CH * NUM_SLOTS;
    logic [15:0] beat_cnt;

    always_ff @(posedge clk) begin
        if (rst) beat_cnt <= '0;
        else if (payload_phase && q_valid && q_ready)
            beat_cnt <= q_last ? 16'd0 : beat_cnt + 16'd1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!q_valid && !smp_ready && !q_last));

    // R9
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        q_last |-> (q_valid && payload_phase));

    // R10
    hdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_phase && q_valid && !q_ready) |=> (q_valid && $stable(q_data)));

    // R10
    pass_ready_chk: assert property (@(posedge clk) disable iff (rst)
        smp_ready |-> (q_ready && payload_phase));

    // R2
    end_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_ready && q_last) |=> !q_valid);

    // R4
    beat_count_chk: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_ready && q_last) |-> (beat_cnt == 16'(TOTAL - 1)));
endmodule

bind iso_pkt_asm iso_pkt_asm_chk #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS)) i_chk (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_ready(q_ready),
    .q_last(q_last), .q_data(q_data), .smp_ready(smp_ready),
    .hdr_phase(hdr_phase), .payload_phase(payload_phase)
);

// File: tb/test_iso_pkt_asm.sv
module test_iso_pkt_asm;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 28;
    localparam int NSL   = 7;
    localparam int NPAY  = NCH * NSL;
    localparam int NQ    = NPAY + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_start = 1'b0;
    logic [15:0] rx_count = '0, txbuf_fill = '0;
    logic [7:0]  aux_a = '0, aux_b = '0, frame_num = '0, clk_phase = '0;
    logic        smp_valid = 1'b0, smp_ready;
    logic [23:0] smp_data = '0;
    logic        q_valid, q_ready = 1'b0, q_last;
    logic [31:0] q_data;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iso_pkt_asm #(.NUM_CH(NCH), .NUM_SLOTS(NSL)) i_iso_pkt_asm (
        .clk(clk), .rst(rst), .pkt_start(pkt_start), .rx_count(rx_count),
        .txbuf_fill(txbuf_fill), .aux_a(aux_a), .aux_b(aux_b),
        .frame_num(frame_num), .clk_phase(clk_phase), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .smp_data(smp_data), .q_valid(q_valid),
        .q_ready(q_ready), .q_data(q_data), .q_last(q_last)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] smpf(input int p);
        return 24'(p * 24'h010203) ^ 24'hA5C3E1;
    endfunction

    function automatic logic [7:0] exp_low(input int ch, input logic [15:0] rxc,
        input logic [15:0] txb, input logic [7:0] aa, input logic [7:0] ab,
        input logic [7:0] fr, input logic [7:0] ph);
        case (ch % 8)
            0: return txb[7:0];
            1: return rxc[7:0];
            2: return aa;
            3: return ab;
            4: return rxc[15:8];
            5: return txb[15:8];
            6: return fr;
            default: return ph;
        endcase
    endfunction

    // mode bit0: downstream stalls, bit1: upstream gaps
    task automatic run_packet(input int mode, input logic [15:0] rxc,
        input logic [15:0] txb, input logic [7:0] aa, input logic [7:0] ab,
        input bit vary_frame, input bit poke_start);
        int k = 0;
        int cyc = 0;
        logic [7:0] fr_s = 8'h00;
        logic [7:0] ph_s = 8'h00;
        logic [31:0] exp_q;
        @(negedge clk);
        rx_count = rxc; txbuf_fill = txb; aux_a = aa; aux_b = ab;
        pkt_start = 1'b1;
        while (k < NQ && cyc < 4000) begin
            @(negedge clk);
            pkt_start = (poke_start && k == 60) ? 1'b1 : 1'b0;
            // R7: per-packet inputs move after start; output must not follow
            rx_count = ~rxc; txbuf_fill = ~txb; aux_a = ~aa; aux_b = ~ab;
            q_ready   = (mode[0] && (cyc % 3 == 1)) ? 1'b0 : 1'b1;
            smp_valid = (mode[1] && (cyc % 4 == 2)) ? 1'b0 : 1'b1;
            smp_data  = smpf((k < 2) ? 0 : k - 2);
            frame_num = vary_frame ? 8'(cyc * 3 + 1) : 8'h3C;
            clk_phase = vary_frame ? 8'(cyc * 5 + 7) : 8'hC3;
            #1;
            if (k < 2) begin
                exp_q = (k == 0) ? {16'(NPAY * 4), 16'h0000} : 32'h0;
                // R10: header offered regardless of downstream readiness
                check(q_valid == 1'b1, "R10 header valid", {31'b0, q_valid}, 32'h1);
                check(q_data == exp_q, "R3 header quadlet", q_data, exp_q);
                check(smp_ready == 1'b0, "R10 no sample taken in header", {31'b0, smp_ready}, 32'h0);
            end else begin
                check(smp_ready == q_ready, "R10 smp_ready follows q_ready", {31'b0, smp_ready}, {31'b0, q_ready});
                check(q_valid == smp_valid, "R10 q_valid follows smp_valid", {31'b0, q_valid}, {31'b0, smp_valid});
            end
            if (q_valid && q_ready) begin
                if (k >= 2) begin
                    if ((k - 2) % NCH == 0) begin
                        fr_s = frame_num;
                        ph_s = clk_phase;
                    end
                    // R4 R5 R6 R8
                    exp_q = {smpf(k - 2), exp_low((k - 2) % NCH, rxc, txb, aa, ab, fr_s, ph_s)};
                    check(q_data == exp_q, "R4/R5/R6/R8 payload quadlet", q_data, exp_q);
                end
                // R9
                check(q_last == (k == NQ - 1), "R9 last flag", {31'b0, q_last}, {31'b0, k == NQ - 1});
                k++;
            end
            cyc++;
        end
        check(k == NQ, "R4 quadlet count", 32'(k), 32'(NQ));
        pkt_start = 1'b0; q_ready = 1'b1; smp_valid = 1'b1;
        repeat (3) begin
            @(negedge clk); #1;
            // R2: idle after last, busy start not remembered
            check(q_valid == 1'b0, "R2 idle after packet", {31'b0, q_valid}, 32'h0);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1; q_ready = 1'b1; smp_valid = 1'b1; pkt_start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        check(q_valid == 1'b0, "R1 q_valid after reset", {31'b0, q_valid}, 32'h0);
        check(smp_ready == 1'b0, "R1 smp_ready after reset", {31'b0, smp_ready}, 32'h0);
        check(q_last == 1'b0, "R1 q_last after reset", {31'b0, q_last}, 32'h0);
    endtask

    task automatic test_plain();       run_packet(0, 16'h1234, 16'h5678, 8'h9A, 8'hBC, 1'b0, 1'b0); endtask
    task automatic test_out_stall();   run_packet(1, 16'hA1B2, 16'hC3D4, 8'h11, 8'h22, 1'b0, 1'b0); endtask
    task automatic test_in_gaps();     run_packet(2, 16'h0F0E, 16'h0D0C, 8'h33, 8'h44, 1'b0, 1'b0); endtask
    task automatic test_frame_moves(); run_packet(3, 16'hFEDC, 16'hBA98, 8'h55, 8'h66, 1'b1, 1'b0); endtask
    task automatic test_busy_start();  run_packet(1, 16'h2468, 16'h1357, 8'h77, 8'h88, 1'b1, 1'b1); endtask
    task automatic test_back_to_back();
        run_packet(0, 16'h0001, 16'hFFFF, 8'h00, 8'hFF, 1'b1, 1'b0);
        run_packet(2, 16'h8000, 16'h0100, 8'hAA, 8'h55, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        test_reset();
        test_plain();
        test_out_stall();
        test_in_gaps();
        test_frame_moves();
        test_busy_start();
        test_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule